// File: doc/BRIEF.md
# Multi-Mode DMA Channel Priority Arbiter

This block decides which DMA channel gets the transfer engine. Each cycle it looks at the request lines of up to eight channels. It then issues a registered one-hot grant and a flag that marks the grant as valid. The block carries no data and counts no transfers.

A 2-bit mode input selects the arbitration policy at run time. Three settings apply fixed priority orders. The orders are built from groups of four channels, each group using the same pattern. The fourth setting rotates priority among the channels. A global enable gates the whole block.

Once a channel holds a grant, it keeps it until it drops its request or until the engine pulses unit-done. Only then does the block arbitrate again. Arbitration and hand-over happen in the same cycle, so no idle cycle separates two grants.

Top module: `dma_prio_arb`

## Requirements
- R1: The grant is one-hot or zero. It is registered, so it reflects the inputs sampled at the previous rising clock edge.
- R2: grant_valid is high exactly when the grant is non-zero. With no request present, grant_valid stays low.
- R3: While enable is low, the next cycle shows a zero grant and grant_valid low.
- R4: Mode value 0 gives fixed priority, highest first, in the order 0,1,2,3,4,5,6,7.
- R5: Mode value 1 gives fixed priority, highest first, in the order 0,2,3,1,4,6,7,5.
- R6: Mode value 2 gives fixed priority, highest first, in the order 2,0,1,3,6,4,5,7.
- R7: Mode value 3 rotates priority. After a grant, the served channel becomes lowest priority, and the search for the next grant starts at the channel above it, wrapping from 7 to 0.
- R8: A granted channel keeps its grant while its request stays high and unit_done is low. Other requests have no effect during that time.
- R9: Any change of the mode value resets the rotation start to channel 0. The new mode governs the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global arbitration enable |
| mode | input | 2 | Priority policy select (0..3) |
| req | input | NCH | Per-channel request lines |
| unit_done | input | 1 | Granted channel finished its unit; re-arbitrate |
| grant | output | NCH | Registered one-hot grant |
| grant_valid | output | 1 | Grant is present |

## Verification
In each fixed mode, the bench raises all eight requests and removes the winner one at a time. The resulting grant sequence tells each permutation apart from the others.

With all requests high and unit_done held, rotation must step through all eight channels and wrap. A sparse request pair checks that a served channel drops behind the other requester. A switch to another mode and back shows that the rotation start is reset, not kept.

A lower-numbered request that arrives during a held grant separates holding from re-arbitration. Tests with enable low and with no request cover the idle outputs.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ARB_SEQ    = 2'd0,
    ARB_PERM_A = 2'd1,
    ARB_PERM_B = 2'd2,
    ARB_ROTATE = 2'd3
  } arb_mode_e;

  localparam int unsigned GROUP_SZ = 4;
  localparam int unsigned N_FIXED  = 3;

  // Channel that occupies priority slot 'pos' (0 = highest) in fixed mode 'md'.
  function automatic int unsigned slot_channel(input int unsigned md, input int unsigned pos);
    int unsigned off;
    int unsigned base;
    int unsigned sel;
    off  = pos % GROUP_SZ;
    base = pos - off;
    case (md)
      1: case (off)
           0: sel = 0;
           1: sel = 2;
           2: sel = 3;
           default: sel = 1;
         endcase
      2: case (off)
           0: sel = 2;
           1: sel = 0;
           2: sel = 1;
           default: sel = 3;
         endcase
      default: sel = off;
    endcase
    return base + sel;
  endfunction

endpackage

// File: rtl/dma_arb_fixed.sv
module dma_arb_fixed
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned MODE = 0
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt,
  output logic           any
);

  logic [NCH-1:0] ord_req;
  logic [NCH-1:0] ord_sel;

  // Reorder requests into priority slots.
  for (genvar p = 0; p < NCH; p++) begin : g_slot
    localparam int unsigned CH = slot_channel(MODE, p);
    assign ord_req[p] = req[CH];
    assign gnt[CH]    = ord_sel[p];
  end

  // First occupied slot wins.
  always_comb begin
    ord_sel = '0;
    any     = 1'b0;
    for (int p = 0; p < NCH; p++) begin
      if (!any && ord_req[p]) begin
        ord_sel[p] = 1'b1;
        any        = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_arb_rotate.sv
module dma_arb_rotate #(
  parameter int unsigned NCH = 8,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic [CW-1:0]  start,
  output logic [NCH-1:0] gnt,
  output logic [CW-1:0]  win,
  output logic           any
);

  logic [CW-1:0] idx;

  always_comb begin
    any = 1'b0;
    win = '0;
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      idx = start + CW'(i);
      if (!any && req[idx]) begin
        any = 1'b1;
        win = idx;
      end
    end
    gnt = '0;
    if (any) gnt[win] = 1'b1;
  end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [1:0]     mode,
  input  logic [NCH-1:0] req,
  input  logic           unit_done,
  output logic [NCH-1:0] grant,
  output logic           grant_valid
);

  logic [NCH-1:0] grant_q, grant_d;
  logic           valid_q, valid_d;
  logic [CW-1:0]  ptr_q, ptr_d;
  logic [1:0]     mode_q;

  logic [NCH-1:0] fix_gnt [N_FIXED];
  logic           fix_any [N_FIXED];
  logic [NCH-1:0] rr_gnt;
  logic [CW-1:0]  rr_win;
  logic           rr_any;
  logic [CW-1:0]  rr_start;
  logic           mode_chg;
  logic           hold;
  logic [NCH-1:0] sel_gnt;
  logic           sel_any;

  for (genvar m = 0; m < N_FIXED; m++) begin : g_fixed
    dma_arb_fixed #(.NCH(NCH), .MODE(m)) u_fixed (
      .req (req),
      .gnt (fix_gnt[m]),
      .any (fix_any[m])
    );
  end

  assign mode_chg = (mode != mode_q);
  assign rr_start = mode_chg ? '0 : ptr_q;

  dma_arb_rotate #(.NCH(NCH)) u_rotate (
    .req   (req),
    .start (rr_start),
    .gnt   (rr_gnt),
    .win   (rr_win),
    .any   (rr_any)
  );

  always_comb begin
    case (arb_mode_e'(mode))
      ARB_SEQ:    begin sel_gnt = fix_gnt[0]; sel_any = fix_any[0]; end
      ARB_PERM_A: begin sel_gnt = fix_gnt[1]; sel_any = fix_any[1]; end
      ARB_PERM_B: begin sel_gnt = fix_gnt[2]; sel_any = fix_any[2]; end
      default:    begin sel_gnt = rr_gnt;     sel_any = rr_any;     end
    endcase
  end

  assign hold = valid_q && (|(grant_q & req)) && !unit_done;

  always_comb begin
    grant_d = grant_q;
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (!enable) begin
      grant_d = '0;
      valid_d = 1'b0;
    end else if (!hold) begin
      grant_d = sel_gnt;
      valid_d = sel_any;
    end
    if (enable && !hold && mode == ARB_ROTATE && rr_any)
      ptr_d = rr_win + CW'(1);
    else if (mode_chg)
      ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      valid_q <= 1'b0;
      ptr_q   <= '0;
      mode_q  <= '0;
    end else begin
      grant_q <= grant_d;
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
      mode_q  <= mode;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = valid_q;

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int unsigned NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic [1:0]     mode,
  input logic [NCH-1:0] req,
  input logic           unit_done,
  input logic [NCH-1:0] grant,
  input logic           grant_valid
);

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));

  a_r2_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((grant & $past(req)) != '0));

  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !grant_valid);

  a_r4_seq_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !grant_valid && mode == 2'd0 && req != '0)
      |=> grant == ($past(req) & (~$past(req) + 1'b1)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && grant_valid && ((grant & req) != '0) && !unit_done)
      |=> grant == $past(grant));

endmodule

bind dma_prio_arb dma_arb_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .mode        (mode),
  .req         (req),
  .unit_done   (unit_done),
  .grant       (grant),
  .grant_valid (grant_valid)
);

// File: tb/dma_prio_arb_bench.sv
module dma_prio_arb_bench;

  logic       clk;
  logic       rst_n;
  logic       enable;
  logic [1:0] mode;
  logic [7:0] req;
  logic       unit_done;
  logic [7:0] grant;
  logic       grant_valid;

  int checks;
  int errors;
  bit done;

  dma_prio_arb #(.NCH(8)) u_dma_prio_arb (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .req(req), .unit_done(unit_done), .grant(grant), .grant_valid(grant_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    enable = 1'b0; req = '0; unit_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic walk(input string rq, input logic [1:0] md, input int ord [8]);
    go_idle();
    enable = 1'b1; mode = md; req = 8'hFF;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(rq, grant, 8'(1) << ord[k]);
      chk(rq, {7'd0, grant_valid}, 8'd1);
      req = req & ~grant;
    end
    @(negedge clk);
    chk({rq, " empty"}, {7'd0, grant_valid}, 8'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset grant", grant, 8'h00);
    chk("R2 reset valid", {7'd0, grant_valid}, 8'd0);
  endtask

  task automatic t_hold();
    go_idle();
    enable = 1'b1; mode = 2'd0; req = 8'h04;
    @(negedge clk); chk("R8 first grant", grant, 8'h04);
    req = 8'h05;
    @(negedge clk); chk("R8 held despite ch0", grant, 8'h04);
    @(negedge clk); chk("R8 still held", grant, 8'h04);
    unit_done = 1'b1;
    @(negedge clk); chk("R8 release on unit_done", grant, 8'h01);
    unit_done = 1'b0; req = 8'h04;
    @(negedge clk); chk("R8 release on req drop", grant, 8'h04);
  endtask

  task automatic t_enable();
    @(negedge clk);
    enable = 1'b0; req = 8'hFF;
    @(negedge clk);
    chk("R3 disabled grant", grant, 8'h00);
    chk("R3 disabled valid", {7'd0, grant_valid}, 8'd0);
    enable = 1'b1; req = 8'h00;
    @(negedge clk);
    chk("R2 no request valid", {7'd0, grant_valid}, 8'd0);
  endtask

  task automatic t_rotate();
    go_idle();
    enable = 1'b1; mode = 2'd3; req = 8'hFF;
    @(negedge clk); chk("R7 first", grant, 8'h01);
    unit_done = 1'b1;
    for (int k = 1; k < 9; k++) begin
      @(negedge clk);
      chk("R7 rotation", grant, 8'(1) << (k % 8));
    end
    req = 8'h05;
    @(negedge clk); chk("R7 sparse a", grant, 8'h04);
    @(negedge clk); chk("R7 sparse b", grant, 8'h01);
    @(negedge clk); chk("R7 sparse c", grant, 8'h04);
    req = 8'hFF; mode = 2'd1;
    @(negedge clk); chk("R9 new mode used", grant, 8'h01);
    mode = 2'd3;
    @(negedge clk); chk("R9 pointer reset", grant, 8'h01);
    @(negedge clk); chk("R9 continues", grant, 8'h02);
    unit_done = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; enable = 1'b0; mode = 2'd0; req = '0; unit_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    walk("R4 mode0", 2'd0, '{0, 1, 2, 3, 4, 5, 6, 7});
    walk("R5 mode1", 2'd1, '{0, 2, 3, 1, 4, 6, 7, 5});
    walk("R6 mode2", 2'd2, '{2, 0, 1, 3, 6, 4, 5, 7});
    t_hold();
    t_enable();
    t_rotate();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule